// File: doc/BRIEF.md
# Synchronous Burst SRAM Access Controller

This block models the synchronous side of a flow-through burst SRAM with its own small storage array. On each rising clock edge it samples three chip selects, two address strobes (one for a processor, one for a cache controller), an advance control, the global-write, byte-write-enable and per-lane select inputs, the address and the write data. A new address load seeds a 2-bit wraparound burst counter. The counter then steps or holds under the advance control. A strap input picks linear or interleaved beat order.

Read data is flow-through: after an edge it comes straight from the array, addressed by the registered burst address, with no output register. The block does not drive a shared bus itself. It presents the read word together with a drive-enable, which a pad ring uses to steer a common I/O bus. The drive-enable is forced off during write cycles, while deselected, on the first clock after leaving the deselected state, while the output enable is high, and during sleep.

The interface is cycle-timed: every edge is an access slot, and there is no back-pressure in either direction. The sleep request is asynchronous. It takes effect, and is released, with two clocks of latency. While asleep the array keeps its contents.

Top module: `burst_sram_ctrl`

## Requirements
- R1: When both strobes are low and chip select `sel_a_n` is low, the processor strobe wins. The cycle is a read, and no byte is written, whatever the write inputs say.
- R2: A load by the processor strobe is always a read and ignores the write inputs at that edge. A write to the burst address can happen on any later edge of the same burst.
- R3: A load by the controller strobe (with the processor strobe not honoured) writes `wdata` to the loaded address at that same edge if the write inputs indicate a write. Otherwise it is a read. After a write edge, `rdata_en` is 0.
- R4: While `sel_a_n` is high, the processor strobe is ignored entirely. With the controller strobe high as well, the edge acts as a burst continue.
- R5: A load seeds the burst from `addr[1:0]` at step 0. On an edge with neither strobe honoured, `step_n` low advances the step by one (wrapping 3 to 0) and `step_n` high holds the address. Such an edge reads, or writes the resulting address when the write inputs say so.
- R6: With `order_ilv`=1 the low two address bits are the start XOR the step. With `order_ilv`=0 they are the start plus the step, modulo 4. The upper address bits stay fixed for the whole burst.
- R7: Lane i (bits 8i+7..8i) is written when `all_wr_n` is 0, or when `lane_wr_n` is 0 and `lane_sel_n[i]` is 0. Any mix of lanes is allowed. `lane_wr_n` low with every select high is a read.
- R8: A load with `sel_a_n` high, `sel_b` low or `sel_c_n` high deselects the block. `rdata_en` then stays 0 until a selecting load.
- R9: `rdata_en` is 1 exactly when the current cycle is a selected read, `oe_n` is low, the block is awake, and the cycle is not masked under R10. `rdata` is then the array word at the current burst address; otherwise `rdata` is 0.
- R10: On the first clock after a selecting load that leaves the deselected state, `rdata_en` is 0.
- R11: `sleep_req` forces `rdata_en` low from the second edge after it rises. The next edge drops the access and deselects. On release, strobes are ignored for two more edges. Array contents survive sleep.
- R12: After reset the block is deselected and `rdata_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_a_n | input | 1 | Chip select A, active low; also gates the processor strobe |
| sel_b | input | 1 | Chip select B, active high |
| sel_c_n | input | 1 | Chip select C, active low |
| cpu_strb_n | input | 1 | Processor address strobe, active low |
| ctl_strb_n | input | 1 | Controller address strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| all_wr_n | input | 1 | Write all lanes, active low |
| lane_wr_n | input | 1 | Byte-write enable, active low |
| lane_sel_n | input | LANES | Per-lane write select, active low |
| addr | input | AW | Word address |
| wdata | input | 8*LANES | Write data |
| oe_n | input | 1 | Output enable, active low, combinational |
| order_ilv | input | 1 | Burst order strap: 1 interleaved, 0 linear |
| sleep_req | input | 1 | Asynchronous sleep request, active high |
| rdata | output | 8*LANES | Flow-through read word, 0 when not driven |
| rdata_en | output | 1 | Bus drive enable for `rdata` |

## Verification
A behavioural model runs alongside the design, and the bench compares `rdata_en` and `rdata` with it on every clock. The model is exercised with processor-started bursts from all four start offsets in both orders, which separates the XOR walk from the modulo-4 walk. Suspend sequences separate holding the address from advancing it. Strobe collisions, processor strobes while `sel_a_n` is high, and write inputs raised on the load edge separate the priority and first-cycle write rules. Deselect-then-reload, output-enable toggling and a sleep round trip with strobes in the guard window expose the drive masking and the retention of array contents.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
  // Low two address bits for a burst beat
  function automatic logic [1:0] beat_offset(input logic [1:0] start,
                                             input logic [1:0] step,
                                             input logic       ilv);
    return ilv ? (start ^ step) : (start + step);
  endfunction
endpackage

// File: rtl/bsram_sleep_sync.sv
module bsram_sleep_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic dozing
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], req};
  end

  assign dozing = chain_q[STAGES-1];
endmodule

// File: rtl/bsram_burst_ctr.sv
module bsram_burst_ctr #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          adv,
  input  logic [AW-1:0] ld_addr,
  input  logic          ilv,
  output logic [AW-1:0] cur_addr,
  output logic [AW-1:0] use_addr
);
  import bsram_pkg::*;

  logic [AW-1:0] base_q, base_d;
  logic [1:0]    step_q, step_d;

  always_comb begin
    base_d = load ? ld_addr : base_q;
    step_d = load ? 2'd0 : (step_q + 2'(adv));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      step_q <= '0;
    end else begin
      base_q <= base_d;
      step_q <= step_d;
    end
  end

  assign cur_addr = {base_q[AW-1:2], beat_offset(base_q[1:0], step_q, ilv)};
  assign use_addr = {base_d[AW-1:2], beat_offset(base_d[1:0], step_d, ilv)};
endmodule

// File: rtl/bsram_array.sv
module bsram_array #(
  parameter int DEPTH = 64,
  parameter int LANES = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int DW = 8 * LANES
) (
  input  logic             clk,
  input  logic [LANES-1:0] we,
  input  logic [AW-1:0]    waddr,
  input  logic [DW-1:0]    wdata,
  input  logic [AW-1:0]    raddr,
  output logic [DW-1:0]    rdata
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
      if (we[g]) cells[waddr] <= wdata[8*g +: 8];
    end

    assign rdata[8*g +: 8] = cells[raddr];
  end
endmodule

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl #(
  parameter int DEPTH = 64,
  parameter int LANES = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int DW = 8 * LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_a_n,
  input  logic             sel_b,
  input  logic             sel_c_n,
  input  logic             cpu_strb_n,
  input  logic             ctl_strb_n,
  input  logic             step_n,
  input  logic             all_wr_n,
  input  logic             lane_wr_n,
  input  logic [LANES-1:0] lane_sel_n,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic             oe_n,
  input  logic             order_ilv,
  input  logic             sleep_req,
  output logic [DW-1:0]    rdata,
  output logic             rdata_en
);
  logic             dozing;
  logic             selected, cpu_take, ctl_take, load_any, wr_req;
  logic             ctr_load, ctr_adv, do_write;
  logic [LANES-1:0] lane_mask, lane_we;
  logic [AW-1:0]    cur_addr, use_addr;
  logic [DW-1:0]    arr_q;
  logic             active_q, rd_q, fresh_q;

  bsram_sleep_sync #(.STAGES(2)) u_sleep (
    .clk(clk), .rst_n(rst_n), .req(sleep_req), .dozing(dozing)
  );

  always_comb begin
    selected  = ~sel_a_n & sel_b & ~sel_c_n;
    cpu_take  = ~cpu_strb_n & ~sel_a_n;
    ctl_take  = ~ctl_strb_n & ~cpu_take;
    load_any  = ~dozing & (cpu_take | ctl_take);
    wr_req    = ~all_wr_n | (~lane_wr_n & ~&lane_sel_n);
    lane_mask = ~all_wr_n ? '1 : (lane_wr_n ? '0 : ~lane_sel_n);
    ctr_load  = load_any & selected;
    ctr_adv   = ~dozing & ~load_any & active_q & ~step_n;
    do_write  = ~dozing & ((ctr_load & ctl_take & wr_req) |
                           (~load_any & active_q & wr_req));
    lane_we   = do_write ? lane_mask : '0;
  end

  bsram_burst_ctr #(.AW(AW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(ctr_load), .adv(ctr_adv),
    .ld_addr(addr), .ilv(order_ilv), .cur_addr(cur_addr), .use_addr(use_addr)
  );

  bsram_array #(.DEPTH(DEPTH), .LANES(LANES)) u_arr (
    .clk(clk), .we(lane_we), .waddr(use_addr), .wdata(wdata),
    .raddr(cur_addr), .rdata(arr_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      rd_q     <= 1'b0;
      fresh_q  <= 1'b0;
    end else if (dozing) begin
      active_q <= 1'b0;
      rd_q     <= 1'b0;
      fresh_q  <= 1'b0;
    end else if (load_any) begin
      if (selected) begin
        active_q <= 1'b1;
        fresh_q  <= ~active_q;
        rd_q     <= ~(ctl_take & wr_req);
      end else begin
        active_q <= 1'b0;
        rd_q     <= 1'b0;
        fresh_q  <= 1'b0;
      end
    end else if (active_q) begin
      rd_q    <= ~wr_req;
      fresh_q <= 1'b0;
    end else begin
      fresh_q <= 1'b0;
    end
  end

  assign rdata_en = active_q & rd_q & ~fresh_q & ~oe_n & ~dozing;
  assign rdata    = rdata_en ? arr_q : '0;
endmodule

// File: rtl/bsram_chk.sv
module bsram_chk #(
  parameter int LANES = 4,
  localparam int DW = 8 * LANES
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sel_a_n,
  input logic             sel_b,
  input logic             sel_c_n,
  input logic             cpu_strb_n,
  input logic             ctl_strb_n,
  input logic             all_wr_n,
  input logic             lane_wr_n,
  input logic [LANES-1:0] lane_sel_n,
  input logic             oe_n,
  input logic             dozing,
  input logic [DW-1:0]    rdata,
  input logic             rdata_en
);
  logic sel_ok, takes, off_q;

  assign sel_ok = ~sel_a_n & sel_b & ~sel_c_n;
  assign takes  = ~dozing & ((~cpu_strb_n & ~sel_a_n) | ~ctl_strb_n);

  // Observed deselected history, kept independently of the design
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           off_q <= 1'b1;
    else if (dozing)      off_q <= 1'b1;
    else if (takes)       off_q <= ~sel_ok;
  end

  a_r8_deselect_z: assert property (@(posedge clk) disable iff (!rst_n)
    takes && !sel_ok |=> !rdata_en);

  a_r3_write_z: assert property (@(posedge clk) disable iff (!rst_n)
    !dozing && (sel_a_n || cpu_strb_n) && !ctl_strb_n && sel_ok &&
    (!all_wr_n || (!lane_wr_n && !(&lane_sel_n))) |=> !rdata_en);

  a_r10_first_mask: assert property (@(posedge clk) disable iff (!rst_n)
    off_q && takes && sel_ok |=> !rdata_en);

  a_r11_sleep_z: assert property (@(posedge clk) disable iff (!rst_n)
    dozing |-> !rdata_en);

  a_r9_oe_z: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !rdata_en);

  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata_en |-> rdata == '0);
endmodule

bind burst_sram_ctrl bsram_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_a_n(sel_a_n), .sel_b(sel_b),
  .sel_c_n(sel_c_n), .cpu_strb_n(cpu_strb_n), .ctl_strb_n(ctl_strb_n),
  .all_wr_n(all_wr_n), .lane_wr_n(lane_wr_n), .lane_sel_n(lane_sel_n),
  .oe_n(oe_n), .dozing(dozing), .rdata(rdata), .rdata_en(rdata_en)
);

// File: tb/burst_sram_ctrl_test.sv
`timescale 1ns/1ps
module burst_sram_ctrl_test;
  localparam int DEPTH = 64;
  localparam int LANES = 4;
  localparam int AW = 6;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_a_n = 1'b0, sel_b = 1'b1, sel_c_n = 1'b0;
  logic cpu_strb_n = 1'b1, ctl_strb_n = 1'b1, step_n = 1'b1;
  logic all_wr_n = 1'b1, lane_wr_n = 1'b1;
  logic [LANES-1:0] lane_sel_n = '1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic oe_n = 1'b0, order_ilv = 1'b0, sleep_req = 1'b0;
  logic [DW-1:0] rdata;
  logic rdata_en;

  int checks = 0, fails = 0;
  bit done = 0;
  string tag = "R12";

  always #2 clk = ~clk;

  burst_sram_ctrl #(.DEPTH(DEPTH), .LANES(LANES)) uut (.*);

  // Behavioural reference
  logic [DW-1:0] mref [DEPTH];
  bit m_act, m_rd, m_fresh, ms1, ms2;
  int m_base, m_step;

  function automatic int ref_addr();
    int lo;
    lo = order_ilv ? ((m_base % 4) ^ m_step) : (((m_base % 4) + m_step) % 4);
    return (m_base / 4) * 4 + lo;
  endfunction

  function automatic void ref_write(int a);
    for (int i = 0; i < LANES; i++)
      if (!all_wr_n || (!lane_wr_n && !lane_sel_n[i])) mref[a][8*i +: 8] = wdata[8*i +: 8];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; m_rd = 0; m_fresh = 0; ms1 = 0; ms2 = 0; m_base = 0; m_step = 0;
    end else begin
      bit pt, ct, sl, wr;
      if (ms2) begin
        m_act = 0; m_rd = 0; m_fresh = 0;
      end else begin
        pt = !cpu_strb_n && !sel_a_n;
        ct = !ctl_strb_n && !pt;
        sl = !sel_a_n && sel_b && !sel_c_n;
        wr = !all_wr_n || (!lane_wr_n && lane_sel_n != '1);
        if (pt || ct) begin
          if (sl) begin
            m_fresh = !m_act; m_act = 1; m_base = int'(addr); m_step = 0;
            if (ct && wr) ref_write(int'(addr));
            m_rd = !(ct && wr);
          end else begin
            m_act = 0; m_rd = 0; m_fresh = 0;
          end
        end else if (m_act) begin
          if (!step_n) m_step = (m_step + 1) % 4;
          if (wr) ref_write(ref_addr());
          m_rd = !wr; m_fresh = 0;
        end else m_fresh = 0;
      end
      ms2 = ms1; ms1 = sleep_req;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit exp_en;
      logic [DW-1:0] exp_d;
      exp_en = m_act && m_rd && !m_fresh && !oe_n && !ms2;
      exp_d  = exp_en ? mref[ref_addr()] : '0;
      checks++;
      if (rdata_en !== exp_en || rdata !== exp_d) begin
        fails++;
        $display("FAIL %s: en=%0b data=%h expected en=%0b data=%h", tag, rdata_en, rdata, exp_en, exp_d);
      end
    end
  end

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic quiet();
    cpu_strb_n = 1; ctl_strb_n = 1; step_n = 1; all_wr_n = 1; lane_wr_n = 1; lane_sel_n = '1;
    sel_a_n = 0; sel_b = 1; sel_c_n = 0;
  endtask

  task automatic ctl_write(int a, logic [DW-1:0] d);
    ctl_strb_n = 0; all_wr_n = 0; addr = AW'(a); wdata = d; tick(); quiet();
  endtask

  task automatic cpu_burst(int a);
    cpu_strb_n = 0; addr = AW'(a); tick(); quiet();
    step_n = 0; repeat (3) tick(); step_n = 1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R12: reset state seen directly at the ports
    checks++;
    if (rdata_en !== 1'b0 || rdata !== '0) begin
      fails++; $display("FAIL R12: en=%0b data=%h expected en=0 data=0", rdata_en, rdata);
    end
    @(posedge clk); #1;

    tag = "R3"; // controller-strobe writes fill the array
    for (int a = 0; a < DEPTH; a++)
      ctl_write(a, {8'(a), 8'(a + 64), 8'(a + 128), 8'(a ^ 8'h5A)});
    tick();

    tag = "R6"; // every start offset in both orders
    for (int m = 0; m < 2; m++) begin
      order_ilv = m[0];
      for (int s = 0; s < 4; s++) cpu_burst(8 + s);
    end

    tag = "R5"; // suspend then advance with wrap
    order_ilv = 0;
    cpu_strb_n = 0; addr = 6'd23; tick(); quiet();
    tick(); tick(); step_n = 0; tick(); step_n = 1; tick(); step_n = 0; repeat (4) tick(); quiet();

    tag = "R2"; // write inputs at the processor load are ignored; later edge writes
    cpu_strb_n = 0; all_wr_n = 0; addr = 6'd30; wdata = 32'hDEADBEEF; tick(); quiet();
    tick();
    tag = "R7"; // lanes 1 and 3 only
    lane_wr_n = 0; lane_sel_n = 4'b0101; wdata = 32'h11223344; tick(); quiet();
    tick();
    lane_wr_n = 0; lane_sel_n = 4'b1111; wdata = 32'hFFFFFFFF; tick(); quiet();
    ctl_strb_n = 0; addr = 6'd30; tick(); quiet(); tick();

    tag = "R1"; // collision: processor wins, no write
    cpu_strb_n = 0; ctl_strb_n = 0; all_wr_n = 0; addr = 6'd40; wdata = 32'h0BADF00D;
    tick(); quiet(); tick();

    tag = "R4"; // processor strobe ignored while sel_a_n high
    cpu_strb_n = 0; addr = 6'd44; tick(); quiet();
    step_n = 0; tick();
    sel_a_n = 1; cpu_strb_n = 0; addr = 6'd0; tick(); quiet();
    step_n = 0; tick(); quiet(); tick();

    tag = "R8"; // deselect through sel_b low
    ctl_strb_n = 0; sel_b = 0; addr = 6'd12; tick(); quiet();
    step_n = 0; repeat (2) tick(); all_wr_n = 0; wdata = 32'h12345678; tick(); quiet();

    tag = "R10"; // first clock after leaving deselect is masked
    cpu_burst(12);

    tag = "R9"; // output enable gating in a burst
    cpu_strb_n = 0; addr = 6'd50; tick(); quiet();
    oe_n = 1; step_n = 0; tick(); oe_n = 0; tick(); oe_n = 1; tick(); oe_n = 0; tick(); quiet();

    tag = "R11"; // sleep round trip with strobes in the guard window
    cpu_strb_n = 0; addr = 6'd52; tick(); quiet();
    sleep_req = 1; step_n = 0; repeat (5) tick(); quiet();
    sleep_req = 0; ctl_strb_n = 0; all_wr_n = 0; addr = 6'd52; wdata = 32'hCAFECAFE; tick();
    quiet(); cpu_strb_n = 0; addr = 6'd53; tick(); quiet(); tick();
    order_ilv = 1;
    cpu_burst(52);
    cpu_burst(30);
    tick(); tick();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule